// File: doc/BRIEF.md
# Shared-Counter Ramp ADC Digitiser

This block is the digital back end of a multi-channel ramp-and-count converter. A start command begins a conversion. The block raises a ramp-enable output for the analog ramp generator and runs one binary counter that all channels share. The counter value is sent to every channel as a Gray code. Each channel watches its own comparator. The first rising edge of that comparator during the ramp freezes the current Gray code in the channel's result register. The gain range the channel was using is stored in the same update.

When the counter reaches full scale, every channel that has not yet captured a code is given the full-scale code and flagged as saturated. One cycle later a single-cycle done pulse tells the reader that all results are valid. The results then stay unchanged until the next start. The controller issues one start per stored event to digitise a series of events. The comparators are asynchronous to the clock, so each one passes through a synchroniser before its edge is detected.

Top module: `wadc_top`

## Requirements
- R1: After reset, ramp_o, done_o, every result code, every gain bit and every saturation flag are 0.
- R2: A start_i pulse while idle raises ramp_o from the next cycle for exactly 4096 cycles (counter values 0 to 4095). A start_i pulse while the ramp is active is ignored and does not change the count or the results.
- R3: Counter value b is distributed as the Gray code b ^ (b >> 1). Suppose a channel's comparator rises and stays high, changed between edges while the counter shows value T. That channel then captures the code for T+2: two synchroniser flops, then one edge-detect cycle.
- R4: Only the first synchronised rising comparator edge during a ramp is captured; later edges in the same ramp are ignored. A comparator that is already high when the ramp starts never produces a capture.
- R5: A channel with no capture by counter value 4095 receives the full-scale code 12'h800 (the Gray code of 4095) and has its saturation flag set. An edge captured in the cycle the counter shows 4095 gives 12'h800 with no saturation.
- R6: done_o is high for exactly one cycle: the cycle after the counter shows 4095. In that cycle ramp_o is already low. The counter is back at 0 and the shared Gray bus never changes by more than one bit per step while counting.
- R7: Each channel's gain_i value is stored in gain_o together with the result, on capture or on saturation. Channel c's code sits on result_o bits [12c+11:12c] and its flags on bit c of gain_o and sat_o.
- R8: An accepted start clears all results, gain bits and saturation flags to 0. After done_o, every result, gain bit and saturation flag holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-conversion request |
| cmp_i | input | 36 | Per-channel asynchronous comparator outputs (ramp crossed stored level) |
| gain_i | input | 36 | Per-channel gain range in use (1 = high gain) |
| ramp_o | output | 1 | Ramp enable for the analog ramp generator |
| result_o | output | 432 | Gray-coded 12-bit result per channel, channel c at bits [12c+11:12c] |
| gain_o | output | 36 | Gain bit stored with each result |
| sat_o | output | 36 | Per-channel saturation flag |
| done_o | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The assertions assume that a comparator, once it has risen, stays at its level for at least two clock cycles, so the synchroniser sees every transition. They also assume that comparator edges which arrive while idle are settled before the next start. The stimulus changes comparator levels only between clock edges. Every pulse lasts several cycles, and each comparator is returned low a dozen cycles before the next start. The bench drives a deliberate second edge and a level that is already high before start. It does this only to show that both are ignored, not to stress the synchroniser.

// File: rtl/wadc_pkg.sv
package wadc_pkg;

  typedef enum logic {
    WADC_IDLE = 1'b0,
    WADC_RAMP = 1'b1
  } wadc_state_e;

  function automatic logic [31:0] wadc_bin2gray(input logic [31:0] bin);
    return bin ^ (bin >> 1);
  endfunction

endpackage

// File: rtl/wadc_seq.sv
module wadc_seq
  import wadc_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             clr_o,
  output logic             ramp_o,
  output logic             last_o,
  output logic             done_o,
  output logic [CNT_W-1:0] gray_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  wadc_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign clr_o  = start_i && (state_q == WADC_IDLE);
  assign ramp_o = (state_q == WADC_RAMP);
  assign last_o = ramp_o && (cnt_q == CNT_MAX);
  assign done_o = done_q;
  assign gray_o = CNT_W'(wadc_bin2gray(32'(cnt_q)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WADC_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_o;
      if (clr_o) begin
        state_q <= WADC_RAMP;
        cnt_q   <= '0;
      end else if (ramp_o) begin
        if (cnt_q == CNT_MAX) begin
          state_q <= WADC_IDLE;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_o && (cnt_q != CNT_MAX)) |=> (ramp_o && (cnt_q == $past(cnt_q) + CNT_W'(1))));

  assert_done_after_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (done_o && !ramp_o && (cnt_q == '0)));

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_gray_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_o && $past(ramp_o)) |-> ($countones(gray_o ^ $past(gray_o)) <= 1));

endmodule

// File: rtl/wadc_sync.sv
module wadc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);

  // STAGES synchroniser flops plus one history flop for edge detection
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-1:0], async_i};
  end

  assign rise_o = sync_q[STAGES-1] && !sync_q[STAGES];

  assert_rise_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/wadc_channel.sv
module wadc_channel #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ramp_i,
  input  logic             last_i,
  input  logic             rise_i,
  input  logic             gain_i,
  input  logic [CNT_W-1:0] gray_i,
  output logic [CNT_W-1:0] res_o,
  output logic             gain_o,
  output logic             sat_o
);

  localparam logic [CNT_W-1:0] FULL_GRAY = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] res_q;
  logic             gain_q, sat_q, fired_q;
  logic             fire;

  assign fire = ramp_i && rise_i && !fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      gain_q  <= 1'b0;
      sat_q   <= 1'b0;
      fired_q <= 1'b0;
    end else if (clr_i) begin
      res_q   <= '0;
      gain_q  <= 1'b0;
      sat_q   <= 1'b0;
      fired_q <= 1'b0;
    end else if (fire) begin
      res_q   <= gray_i;
      gain_q  <= gain_i;
      fired_q <= 1'b1;
    end else if (last_i && !fired_q) begin
      res_q   <= gray_i;
      gain_q  <= gain_i;
      sat_q   <= 1'b1;
    end
  end

  assign res_o  = res_q;
  assign gain_o = gain_q;
  assign sat_o  = sat_q;

  assert_hold_after_fire_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fired_q && !clr_i) |=> ($stable(res_q) && $stable(gain_q) && !sat_q));

  assert_sat_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_q |-> (res_q == FULL_GRAY));

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((res_q == '0) && !sat_q && !gain_q));

endmodule

// File: rtl/wadc_top.sv
module wadc_top #(
  parameter int unsigned N_CH   = 36,
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [N_CH-1:0]       cmp_i,
  input  logic [N_CH-1:0]       gain_i,
  output logic                  ramp_o,
  output logic [N_CH*CNT_W-1:0] result_o,
  output logic [N_CH-1:0]       gain_o,
  output logic [N_CH-1:0]       sat_o,
  output logic                  done_o
);

  logic             clr_w, ramp_w, last_w;
  logic [CNT_W-1:0] gray_w;

  wadc_seq #(.CNT_W(CNT_W)) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .clr_o   (clr_w),
    .ramp_o  (ramp_w),
    .last_o  (last_w),
    .done_o  (done_o),
    .gray_o  (gray_w)
  );

  assign ramp_o = ramp_w;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic rise_w;

    wadc_sync #(.STAGES(STAGES)) i_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (cmp_i[c]),
      .rise_o  (rise_w)
    );

    wadc_channel #(.CNT_W(CNT_W)) i_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_w),
      .ramp_i (ramp_w),
      .last_i (last_w),
      .rise_i (rise_w),
      .gain_i (gain_i[c]),
      .gray_i (gray_w),
      .res_o  (result_o[c*CNT_W +: CNT_W]),
      .gain_o (gain_o[c]),
      .sat_o  (sat_o[c])
    );
  end

  assert_done_ramp_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ramp_o);

  assert_sat_only_at_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_o != $past(sat_o)) |-> (done_o || (sat_o == '0)));

endmodule

// File: tb/test_wadc_top.sv
module test_wadc_top;

  localparam int N_CH = 36;
  localparam int CW   = 12;
  localparam int FULL = 4095;

  typedef struct {
    logic [N_CH*CW-1:0] res;
    logic [N_CH-1:0]    sat;
    logic [N_CH-1:0]    gain;
  } exp_t;

  logic                 clk_i = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 start_i = 1'b0;
  logic [N_CH-1:0]      cmp_i = '0;
  logic [N_CH-1:0]      gain_i = '0;
  logic                 ramp_o;
  logic [N_CH*CW-1:0]   result_o;
  logic [N_CH-1:0]      gain_o;
  logic [N_CH-1:0]      sat_o;
  logic                 done_o;

  int   n_run = 0;
  int   n_fail = 0;
  int   n_done = 0;
  bit   prev_done = 1'b0;
  exp_t exp_q[$];
  exp_t last_exp;
  int   tt[N_CH];

  always #2 clk_i = ~clk_i;

  wadc_top i_wadc_top (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .cmp_i    (cmp_i),
    .gain_i   (gain_i),
    .ramp_o   (ramp_o),
    .result_o (result_o),
    .gain_o   (gain_o),
    .sat_o    (sat_o),
    .done_o   (done_o)
  );

  function automatic logic [CW-1:0] gray(input int v);
    logic [CW-1:0] b;
    b = CW'(v);
    return b ^ (b >> 1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: scoreboard pop on every done pulse
  always @(negedge clk_i) begin
    if (done_o) begin
      n_done++;
      chk(!prev_done, "R6", "done longer than one cycle", 1, 0);
      chk(!ramp_o, "R6", "ramp high during done", ramp_o, 0);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        for (int c = 0; c < N_CH; c++) begin
          if (e.sat[c])
            chk(result_o[c*CW +: CW] == e.res[c*CW +: CW], "R5", $sformatf("ch%0d code", c),
                result_o[c*CW +: CW], e.res[c*CW +: CW]);
          else
            chk(result_o[c*CW +: CW] == e.res[c*CW +: CW], "R3", $sformatf("ch%0d code", c),
                result_o[c*CW +: CW], e.res[c*CW +: CW]);
          chk(sat_o[c] == e.sat[c], "R5", $sformatf("ch%0d sat", c), sat_o[c], e.sat[c]);
          chk(gain_o[c] == e.gain[c], "R7", $sformatf("ch%0d gain", c), gain_o[c], e.gain[c]);
        end
      end
    end
    prev_done = done_o;
  end

  // driver: builds the expected item, then drives one whole conversion
  task automatic run_conv(input logic [N_CH-1:0] g, input logic [N_CH-1:0] pre,
                          input logic [N_CH-1:0] bnc);
    exp_t e;
    for (int c = 0; c < N_CH; c++) begin
      if (pre[c] || tt[c] < 0 || tt[c] + 2 > FULL) begin
        e.res[c*CW +: CW] = gray(FULL);
        e.sat[c] = 1'b1;
      end else begin
        e.res[c*CW +: CW] = gray(tt[c] + 2);
        e.sat[c] = 1'b0;
      end
      e.gain[c] = g[c];
    end
    exp_q.push_back(e);
    last_exp = e;

    @(negedge clk_i);
    cmp_i  = pre;
    gain_i = g;
    repeat (4) @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k <= FULL; k++) begin
      if (k == 0) chk(ramp_o, "R2", "ramp not raised", ramp_o, 1);
      if (k == 1) begin
        chk(result_o == '0, "R8", "results not cleared", |result_o, 0);
        chk(sat_o == '0, "R8", "sat not cleared", sat_o, 0);
        chk(gain_o == '0, "R8", "gain not cleared", gain_o, 0);
      end
      if (k == 100) start_i = 1'b1;   // R2: ignored while ramping
      if (k == 101) start_i = 1'b0;
      if (k == FULL) begin
        chk(ramp_o, "R2", "ramp dropped early", ramp_o, 1);
        chk(!done_o, "R6", "done early", done_o, 0);
      end
      for (int c = 0; c < N_CH; c++) begin
        if (!pre[c] && tt[c] >= 0) begin
          if (k == tt[c]) cmp_i[c] = 1'b1;
          if (bnc[c] && k == tt[c] + 5) cmp_i[c] = 1'b0;
          if (bnc[c] && k == tt[c] + 9) cmp_i[c] = 1'b1;   // R4 second edge
        end
      end
      @(negedge clk_i);
    end
    // done cycle is checked by the monitor at this negedge
    @(negedge clk_i);
    cmp_i = '0;
    chk(!ramp_o, "R2", "ramp after 4096 cycles", ramp_o, 0);
    chk(!done_o, "R6", "done not single cycle", done_o, 0);
    repeat (8) @(negedge clk_i);
    chk(result_o == last_exp.res, "R8", "results not held", 0, 1);
    chk(sat_o == last_exp.sat, "R8", "sat not held", sat_o, last_exp.sat);
    chk(gain_o == last_exp.gain, "R8", "gain not held", gain_o, last_exp.gain);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R2: watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(!ramp_o, "R1", "ramp after reset", ramp_o, 0);
    chk(!done_o, "R1", "done after reset", done_o, 0);
    chk(result_o == '0, "R1", "results after reset", |result_o, 0);
    chk(sat_o == '0, "R1", "sat after reset", sat_o, 0);
    chk(gain_o == '0, "R1", "gain after reset", gain_o, 0);

    // conversion 1: boundaries (R3, R5) and spread crossings
    for (int c = 0; c < N_CH; c++) tt[c] = (c * 117 + 11) % 4300;
    tt[0] = 0; tt[1] = FULL - 2; tt[2] = FULL - 1; tt[3] = -1;
    run_conv(36'hA_5C3F_0E19, '0, '0);

    // conversion 2: nothing crosses, all saturate (R5, R7)
    for (int c = 0; c < N_CH; c++) tt[c] = -1;
    run_conv('1, '0, '0);

    // conversion 3: pre-high levels and second edges ignored (R4)
    for (int c = 0; c < N_CH; c++) tt[c] = 50 + c * 60;
    run_conv(36'h0_FFFF_0000, 36'h0_0000_00F0, 36'h0_0000_0F00);

    // conversion 4: descending crossings, channel 0 at the last count (R5)
    for (int c = 0; c < N_CH; c++) tt[c] = FULL - c * 113;
    run_conv('0, '0, 36'h8_0000_0003);

    repeat (10) @(negedge clk_i);
    chk(exp_q.size() == 0, "R6", "missing done pulses", exp_q.size(), 0);
    chk(n_done == 4, "R6", "done count", n_done, 4);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule